// File: doc/BRIEF.md
# Single-Cycle Integer Control Decoder

This block is the combinational control unit of a single-cycle 32-bit integer datapath. Its inputs are the nine instruction bits that set an operation apart (the upper five opcode bits, the three funct3 bits and bit 30), plus the equal and less-than results of the branch comparator. From these eleven bits it produces one 15-bit control word. The word holds the next-PC select, the immediate format, the compare mode, the two ALU operand selects, the ALU operation, the memory write strobe, the register write enable and the writeback select.

The branch decision is made inside the decoder. The comparator results feed straight into the next-PC select, so the datapath never sees a separate "branch taken" signal. The decoder recognises these operations: the ten register-register ALU operations, addi, lw, sw, the six conditional branches, jal, jalr, auipc and lui. Every other key gives an all-zero safe word. Fields that an operation does not use are driven to zero, so the output is always fully determined.

Top module: `rv32_ctrl_decoder`

## Requirements
- R1: For opcode[6:2]=01100 the decoder selects rs1 and rs2 as operands (a_sel=0, b_sel=0), sets reg_we=1, wb_sel=2 and imm_sel=0, and sets alu_sel from funct3/bit30 as follows: 000/0 add=0, 000/1 sub=1, 001 sll=2, 010 slt=3, 011 sltu=4, 100 xor=5, 101/0 srl=6, 101/1 sra=7, 110 or=8, 111 and=9. Bit30=1 with any other funct3 is unrecognised.
- R2: The I, U and jump operations all use the add operation (alu_sel=0), b_sel=1 and reg_we=1, with these further settings. Immediate codes are I=1 and U=4. The writeback select is memory=0, ALU=2, PC+4=3. The operand A select is 0 for rs1 and 1 for PC.
  - addi (00100, f3 000): imm I, A rs1, wb ALU.
  - lw (00000, f3 010): imm I, A rs1, wb memory.
  - jalr (11001, f3 000): imm I, A rs1, wb PC+4.
  - jal (11011): imm J=5, A PC, wb PC+4.
  - auipc (00101): imm U, A PC, wb ALU.
  - lui (01101): imm U, alu_sel=10 (pass B), wb ALU.
- R3: sw (01000, f3 010) sets mem_we=1, imm S=2, a_sel=0, b_sel=1, add, reg_we=0 and wb_sel=0. mem_we is 0 for every other key.
- R4: A branch (11000) with funct3 000, 001, 100, 101, 110 or 111 sets imm B=3, a_sel=1, b_sel=1, add and reg_we=0. pc_sel=1 (1 selects the ALU result, 0 selects PC+4) exactly when the condition holds: beq when eq, bne when not eq, blt and bltu when lt, bge and bgeu when not lt.
- R5: br_un is 1 only for bltu (f3 110) and bgeu (f3 111). It is 0 for every other key.
- R6: jal and jalr set pc_sel=1 whatever the comparator inputs are.
- R7: Any unrecognised key gives an all-zero word. This includes branch funct3 010/011, load/store funct3 other than 010, addi's opcode with another funct3, and jalr with funct3 other than 000.
- R8: Bit 30 has no effect on any operation other than the register-register ALU operations, and funct3 has no effect on jal, auipc or lui. Fields an operation does not use are 0.
- R9: For every key that is not a branch, jal or jalr, pc_sel is 0 whatever the comparator inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_hi_i | input | 5 | Instruction opcode bits 6..2 |
| funct3_i | input | 3 | Instruction bits 14..12 |
| alt_i | input | 1 | Instruction bit 30 |
| br_eq_i | input | 1 | Comparator: operands equal |
| br_lt_i | input | 1 | Comparator: rs1 less than rs2 |
| pc_sel_o | output | 1 | 0 selects PC+4, 1 selects the ALU result |
| imm_sel_o | output | 3 | Immediate format (I=1, S=2, B=3, U=4, J=5) |
| br_un_o | output | 1 | Unsigned compare mode |
| a_sel_o | output | 1 | Operand A: 0 rs1, 1 PC |
| b_sel_o | output | 1 | Operand B: 0 rs2, 1 immediate |
| alu_sel_o | output | 4 | ALU operation code |
| mem_we_o | output | 1 | Memory write strobe |
| reg_we_o | output | 1 | Register write enable |
| wb_sel_o | output | 2 | Writeback: 0 memory, 2 ALU, 3 PC+4 |

## Verification
Branch resolution and field decode act in the same evaluation. The comparator flags feed the next-PC select, while the rest of the word comes from the instruction key alone. The bench applies all four flag pairs to every one of the 512 keys, and then applies random keys and flags. This shows whether the flags change pc_sel only for branches, whether they leave jumps redirected and other operations unredirected, and whether they never leak into any other field. Each word is compared in full against a table the bench builds from the requirements.

// File: rtl/rvc_pkg.sv
package rvc_pkg;
  localparam int OP_W    = 5;
  localparam int F3_W    = 3;
  localparam int IMM_W   = 3;
  localparam int ALU_W   = 4;
  localparam int WB_W    = 2;
  localparam int WORD_W  = 1 + IMM_W + 1 + 1 + 1 + ALU_W + 1 + 1 + WB_W;

  localparam logic [OP_W-1:0] OP_LOAD   = 5'b00000;
  localparam logic [OP_W-1:0] OP_IMM    = 5'b00100;
  localparam logic [OP_W-1:0] OP_AUIPC  = 5'b00101;
  localparam logic [OP_W-1:0] OP_STORE  = 5'b01000;
  localparam logic [OP_W-1:0] OP_REG    = 5'b01100;
  localparam logic [OP_W-1:0] OP_LUI    = 5'b01101;
  localparam logic [OP_W-1:0] OP_BRANCH = 5'b11000;
  localparam logic [OP_W-1:0] OP_JALR   = 5'b11001;
  localparam logic [OP_W-1:0] OP_JAL    = 5'b11011;

  localparam logic [IMM_W-1:0] IMM_NONE = 3'd0;
  localparam logic [IMM_W-1:0] IMM_I    = 3'd1;
  localparam logic [IMM_W-1:0] IMM_S    = 3'd2;
  localparam logic [IMM_W-1:0] IMM_B    = 3'd3;
  localparam logic [IMM_W-1:0] IMM_U    = 3'd4;
  localparam logic [IMM_W-1:0] IMM_J    = 3'd5;

  localparam logic [ALU_W-1:0] ALU_ADD  = 4'd0;
  localparam logic [ALU_W-1:0] ALU_SUB  = 4'd1;
  localparam logic [ALU_W-1:0] ALU_SLL  = 4'd2;
  localparam logic [ALU_W-1:0] ALU_SLT  = 4'd3;
  localparam logic [ALU_W-1:0] ALU_SLTU = 4'd4;
  localparam logic [ALU_W-1:0] ALU_XOR  = 4'd5;
  localparam logic [ALU_W-1:0] ALU_SRL  = 4'd6;
  localparam logic [ALU_W-1:0] ALU_SRA  = 4'd7;
  localparam logic [ALU_W-1:0] ALU_OR   = 4'd8;
  localparam logic [ALU_W-1:0] ALU_AND  = 4'd9;
  localparam logic [ALU_W-1:0] ALU_PASSB = 4'd10;

  localparam logic [WB_W-1:0] WB_MEM  = 2'd0;
  localparam logic [WB_W-1:0] WB_ALU  = 2'd2;
  localparam logic [WB_W-1:0] WB_LINK = 2'd3;

  typedef enum logic [3:0] {
    CLS_ILLEGAL, CLS_ALU_R, CLS_ADDI, CLS_LOAD, CLS_STORE,
    CLS_BRANCH, CLS_JALR, CLS_JAL, CLS_AUIPC, CLS_LUI
  } inst_cls_e;

  typedef struct packed {
    logic             pc_sel;
    logic [IMM_W-1:0] imm_sel;
    logic             br_un;
    logic             a_sel;
    logic             b_sel;
    logic [ALU_W-1:0] alu_sel;
    logic             mem_we;
    logic             reg_we;
    logic [WB_W-1:0]  wb_sel;
  } ctrl_word_t;
endpackage

// File: rtl/rvc_classify.sv
module rvc_classify
  import rvc_pkg::*;
(
  input  logic [OP_W-1:0] op_hi_i,
  input  logic [F3_W-1:0] funct3_i,
  input  logic            alt_i,
  output inst_cls_e       cls_o
);
  always_comb begin
    cls_o = CLS_ILLEGAL;
    unique case (op_hi_i)
      OP_REG:    if (!alt_i || funct3_i == 3'b000 || funct3_i == 3'b101) cls_o = CLS_ALU_R;
      OP_IMM:    if (funct3_i == 3'b000) cls_o = CLS_ADDI;
      OP_LOAD:   if (funct3_i == 3'b010) cls_o = CLS_LOAD;
      OP_STORE:  if (funct3_i == 3'b010) cls_o = CLS_STORE;
      OP_BRANCH: if (funct3_i[2:1] != 2'b01) cls_o = CLS_BRANCH;
      OP_JALR:   if (funct3_i == 3'b000) cls_o = CLS_JALR;
      OP_JAL:    cls_o = CLS_JAL;
      OP_AUIPC:  cls_o = CLS_AUIPC;
      OP_LUI:    cls_o = CLS_LUI;
      default:   cls_o = CLS_ILLEGAL;
    endcase
  end
endmodule

// File: rtl/rvc_branch_eval.sv
module rvc_branch_eval
  import rvc_pkg::*;
(
  input  inst_cls_e       cls_i,
  input  logic [F3_W-1:0] funct3_i,
  input  logic            br_eq_i,
  input  logic            br_lt_i,
  output logic            pc_sel_o,
  output logic            br_un_o
);
  logic cond;

  always_comb begin
    // funct3[2] picks lt vs eq, funct3[0] inverts, funct3[1] marks unsigned
    cond = funct3_i[2] ? br_lt_i : br_eq_i;
    if (funct3_i[0]) cond = !cond;
  end

  always_comb begin
    pc_sel_o = 1'b0;
    br_un_o  = 1'b0;
    unique case (cls_i)
      CLS_BRANCH: begin
        pc_sel_o = cond;
        br_un_o  = funct3_i[2] & funct3_i[1];
      end
      CLS_JAL, CLS_JALR: pc_sel_o = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/rvc_field_gen.sv
module rvc_field_gen
  import rvc_pkg::*;
(
  input  inst_cls_e        cls_i,
  input  logic [F3_W-1:0]  funct3_i,
  input  logic             alt_i,
  output logic [IMM_W-1:0] imm_sel_o,
  output logic             a_sel_o,
  output logic             b_sel_o,
  output logic [ALU_W-1:0] alu_sel_o,
  output logic             mem_we_o,
  output logic             reg_we_o,
  output logic [WB_W-1:0]  wb_sel_o
);
  logic [ALU_W-1:0] r_op;

  always_comb begin
    unique case (funct3_i)
      3'b000:  r_op = alt_i ? ALU_SUB : ALU_ADD;
      3'b001:  r_op = ALU_SLL;
      3'b010:  r_op = ALU_SLT;
      3'b011:  r_op = ALU_SLTU;
      3'b100:  r_op = ALU_XOR;
      3'b101:  r_op = alt_i ? ALU_SRA : ALU_SRL;
      3'b110:  r_op = ALU_OR;
      default: r_op = ALU_AND;
    endcase
  end

  always_comb begin
    imm_sel_o = IMM_NONE;
    a_sel_o   = 1'b0;
    b_sel_o   = 1'b1;
    alu_sel_o = ALU_ADD;
    mem_we_o  = 1'b0;
    reg_we_o  = 1'b1;
    wb_sel_o  = WB_ALU;
    unique case (cls_i)
      CLS_ALU_R: begin b_sel_o = 1'b0; alu_sel_o = r_op; end
      CLS_ADDI:  imm_sel_o = IMM_I;
      CLS_LOAD:  begin imm_sel_o = IMM_I; wb_sel_o = WB_MEM; end
      CLS_JALR:  begin imm_sel_o = IMM_I; wb_sel_o = WB_LINK; end
      CLS_JAL:   begin imm_sel_o = IMM_J; a_sel_o = 1'b1; wb_sel_o = WB_LINK; end
      CLS_AUIPC: begin imm_sel_o = IMM_U; a_sel_o = 1'b1; end
      CLS_LUI:   begin imm_sel_o = IMM_U; alu_sel_o = ALU_PASSB; end
      CLS_STORE: begin
        imm_sel_o = IMM_S; mem_we_o = 1'b1; reg_we_o = 1'b0; wb_sel_o = WB_MEM;
      end
      CLS_BRANCH: begin
        imm_sel_o = IMM_B; a_sel_o = 1'b1; reg_we_o = 1'b0; wb_sel_o = WB_MEM;
      end
      default: begin
        b_sel_o = 1'b0; reg_we_o = 1'b0; wb_sel_o = WB_MEM;
      end
    endcase
  end
endmodule

// File: rtl/rv32_ctrl_decoder.sv
module rv32_ctrl_decoder
  import rvc_pkg::*;
(
  input  logic [4:0] op_hi_i,
  input  logic [2:0] funct3_i,
  input  logic       alt_i,
  input  logic       br_eq_i,
  input  logic       br_lt_i,
  output logic       pc_sel_o,
  output logic [2:0] imm_sel_o,
  output logic       br_un_o,
  output logic       a_sel_o,
  output logic       b_sel_o,
  output logic [3:0] alu_sel_o,
  output logic       mem_we_o,
  output logic       reg_we_o,
  output logic [1:0] wb_sel_o
);
  inst_cls_e  cls;
  ctrl_word_t word;

  rvc_classify u_cls (
    .op_hi_i (op_hi_i),
    .funct3_i(funct3_i),
    .alt_i   (alt_i),
    .cls_o   (cls)
  );

  rvc_branch_eval u_br (
    .cls_i   (cls),
    .funct3_i(funct3_i),
    .br_eq_i (br_eq_i),
    .br_lt_i (br_lt_i),
    .pc_sel_o(word.pc_sel),
    .br_un_o (word.br_un)
  );

  rvc_field_gen u_fld (
    .cls_i    (cls),
    .funct3_i (funct3_i),
    .alt_i    (alt_i),
    .imm_sel_o(word.imm_sel),
    .a_sel_o  (word.a_sel),
    .b_sel_o  (word.b_sel),
    .alu_sel_o(word.alu_sel),
    .mem_we_o (word.mem_we),
    .reg_we_o (word.reg_we),
    .wb_sel_o (word.wb_sel)
  );

  assign pc_sel_o  = word.pc_sel;
  assign imm_sel_o = word.imm_sel;
  assign br_un_o   = word.br_un;
  assign a_sel_o   = word.a_sel;
  assign b_sel_o   = word.b_sel;
  assign alu_sel_o = word.alu_sel;
  assign mem_we_o  = word.mem_we;
  assign reg_we_o  = word.reg_we;
  assign wb_sel_o  = word.wb_sel;

  always_comb begin
    assert_store_no_wb_R3: assert (!(word.mem_we && word.reg_we));
    assert_redirect_src_R6: assert (!word.pc_sel || cls inside {CLS_BRANCH, CLS_JAL, CLS_JALR});
    assert_unsigned_br_R5: assert (!word.br_un || cls == CLS_BRANCH);
    assert_safe_word_R7: assert (cls != CLS_ILLEGAL || word == '0);
    assert_link_wb_R2: assert (word.wb_sel != WB_LINK || cls inside {CLS_JAL, CLS_JALR});
  end
endmodule

// File: tb/rv32_ctrl_decoder_test.sv
module rv32_ctrl_decoder_test;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [4:0] op_hi;
  logic [2:0] f3;
  logic       alt, eq, lt;
  logic       pc_sel, br_un, a_sel, b_sel, mem_we, reg_we;
  logic [2:0] imm_sel;
  logic [3:0] alu_sel;
  logic [1:0] wb_sel;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  rv32_ctrl_decoder uut (
    .op_hi_i(op_hi), .funct3_i(f3), .alt_i(alt), .br_eq_i(eq), .br_lt_i(lt),
    .pc_sel_o(pc_sel), .imm_sel_o(imm_sel), .br_un_o(br_un), .a_sel_o(a_sel),
    .b_sel_o(b_sel), .alu_sel_o(alu_sel), .mem_we_o(mem_we), .reg_we_o(reg_we),
    .wb_sel_o(wb_sel)
  );

  // {pc, imm[3], un, a, b, alu[4], mem, we, wb[2]}
  function automatic logic [14:0] pack(input logic p, input logic [2:0] im, input logic u,
      input logic a, input logic b, input logic [3:0] al, input logic m, input logic w,
      input logic [1:0] wb);
    return {p, im, u, a, b, al, m, w, wb};
  endfunction

  function automatic logic [14:0] model(input logic [4:0] o, input logic [2:0] g,
      input logic s, input logic e, input logic l);
    logic [3:0] rop;
    logic take;
    case (g)
      0: rop = s ? 4'd1 : 4'd0;
      1: rop = 4'd2;
      2: rop = 4'd3;
      3: rop = 4'd4;
      4: rop = 4'd5;
      5: rop = s ? 4'd7 : 4'd6;
      6: rop = 4'd8;
      default: rop = 4'd9;
    endcase
    case (g)
      0: take = e;
      1: take = !e;
      4, 6: take = l;
      default: take = !l;
    endcase
    if (o == 5'b01100 && (!s || g == 0 || g == 5)) return pack(0, 0, 0, 0, 0, rop, 0, 1, 2);
    if (o == 5'b00100 && g == 0) return pack(0, 1, 0, 0, 1, 0, 0, 1, 2);
    if (o == 5'b00000 && g == 2) return pack(0, 1, 0, 0, 1, 0, 0, 1, 0);
    if (o == 5'b01000 && g == 2) return pack(0, 2, 0, 0, 1, 0, 1, 0, 0);
    if (o == 5'b11000 && g != 2 && g != 3)
      return pack(take, 3, (g == 6 || g == 7), 1, 1, 0, 0, 0, 0);
    if (o == 5'b11001 && g == 0) return pack(1, 1, 0, 0, 1, 0, 0, 1, 3);
    if (o == 5'b11011) return pack(1, 5, 0, 1, 1, 0, 0, 1, 3);
    if (o == 5'b00101) return pack(0, 4, 0, 1, 1, 0, 0, 1, 2);
    if (o == 5'b01101) return pack(0, 4, 0, 0, 1, 10, 0, 1, 2);
    return '0;
  endfunction

  function automatic string tag_of(input logic [4:0] o);
    case (o)
      5'b01100: return "R1";
      5'b01000: return "R3";
      5'b11000: return "R4";
      5'b00100, 5'b00000, 5'b11001, 5'b11011, 5'b00101, 5'b01101: return "R2";
      default: return "R7";
    endcase
  endfunction

  task automatic apply(input logic [4:0] o, input logic [2:0] g, input logic s,
                       input logic e, input logic l, input string tag);
    logic [14:0] act, exp;
    @(negedge clk);
    op_hi = o; f3 = g; alt = s; eq = e; lt = l;
    #2;
    act = pack(pc_sel, imm_sel, br_un, a_sel, b_sel, alu_sel, mem_we, reg_we, wb_sel);
    exp = model(o, g, s, e, l);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s op=%b f3=%b b30=%b eq=%b lt=%b act=%h exp=%h",
               tag, o, g, s, e, l, act, exp);
    end
  endtask

  initial begin
    op_hi = '0; f3 = '0; alt = 0; eq = 0; lt = 0;
    // all-zero inputs: load opcode, funct3 000 is unrecognised -> safe word (R7)
    apply(5'b00000, 3'b000, 0, 0, 0, "R7");
    // exhaustive sweep: R1 R2 R3 R4 R7 by opcode
    for (int k = 0; k < 512; k++)
      for (int f = 0; f < 4; f++)
        apply(k[8:4], k[3:1], k[0], f[1], f[0], tag_of(k[8:4]));
    // R5 unsigned branches under each flag pair
    for (int f = 0; f < 4; f++) begin
      apply(5'b11000, 3'b110, 1, f[1], f[0], "R5");
      apply(5'b11000, 3'b111, 0, f[1], f[0], "R5");
    end
    // R6 jumps redirect whatever the flags
    for (int f = 0; f < 4; f++) begin
      apply(5'b11011, 3'b011, 1, f[1], f[0], "R6");
      apply(5'b11001, 3'b000, 1, f[1], f[0], "R6");
    end
    // R9 flags toggling under non-control ops leave pc_sel 0
    for (int f = 0; f < 4; f++) begin
      apply(5'b01000, 3'b010, 0, f[1], f[0], "R9");
      apply(5'b01101, 3'b111, 1, f[1], f[0], "R9");
    end
    // R8 bit30 and funct3 ignored outside register ALU ops
    apply(5'b00100, 3'b000, 1, 1, 1, "R8");
    apply(5'b00000, 3'b010, 1, 0, 1, "R8");
    apply(5'b00101, 3'b101, 1, 1, 0, "R8");
    // random mix, fixed seed
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 1000; i++) begin
      logic [10:0] r;
      r = 11'($urandom());
      apply(r[10:6], r[5:3], r[2], r[1], r[0], tag_of(r[10:6]));
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule